// File: doc/BRIEF.md
# Sampling Clock Phase-Frequency Lock Loop

This block steers the local sampling clock of a protection terminal. The clock is a numerically controlled oscillator: a phase accumulator advanced every cycle by an increment, with one sample tick produced each time the accumulator wraps. A proportional-integral loop filter adjusts that increment. Its single error term is the sum of two estimates supplied from outside the block. One is the frequency deviation, which is the power-system frequency minus the clock frequency. The other is the phase deviation, which is the timing offset of this clock against the clocks at the other terminals. When the loop is locked, the samples follow the system frequency, so each set of samples covers exactly one power cycle, and the residual timing error between terminals moves toward zero.

The upstream estimator pulses `upd_i` once for each new estimate. It raises `track_i` when the current at one or more terminals is above the tracking threshold of 0.125 per unit of nominal. Between strobes the increment is held. At every strobe taken with `track_i` low, the block drops back to the fixed nominal increment and clears its integrator, so that tracking later resumes from nominal without stale history.

Top module: `sampclk_lock_loop`

## Requirements
- R1: While `rst` is high, `inc_o` equals NOM_INC (default 1024), `tick_o` is 0 and the integrator is zero.
- R2: At a strobe with `track_i` high, the error is e = `freq_dev_i` + `phase_dev_i` (signed). From the clock edge that samples the strobe, `inc_o` = clamp(NOM_INC + (e >>> KP_SHIFT) + I), where I is the updated integrator value and the shifts are arithmetic.
- R3: At each tracking strobe the integrator adds e >>> KI_SHIFT and saturates at plus or minus INT_LIM (default 64).
- R4: `inc_o` never leaves the range NOM_INC ± (NOM_INC >> CLAMP_SHIFT), which is 896 to 1152 by default.
- R5: At a strobe with `track_i` low, `inc_o` becomes NOM_INC and the integrator is cleared. A later tracking strobe with e = 0 therefore gives exactly NOM_INC.
- R6: With `upd_i` low, `inc_o` holds its value whatever the deviation inputs do.
- R7: `tick_o` is a one-cycle pulse, issued once for each wrap of the ACC_W-bit accumulator. At NOM_INC = 1024 with ACC_W = 16, ticks are exactly 64 cycles apart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| upd_i | input | 1 | One-cycle strobe marking a new deviation estimate |
| track_i | input | 1 | Line current is above the tracking threshold |
| freq_dev_i | input | DEV_W | Signed frequency deviation estimate |
| phase_dev_i | input | DEV_W | Signed phase deviation estimate |
| inc_o | output | ACC_W | Current oscillator increment |
| tick_o | output | 1 | Sample tick, one cycle per accumulator wrap |

## Verification
The integrator state cannot be seen at the ports, and its saturation only shows up once the proportional term has been taken away. To expose it, the stimulus first drives the integrator into its limit with very large deviations. It then issues strobes with zero error, so that `inc_o` equals NOM_INC plus the integrator on its own. The clearing on entry to nominal mode is exposed the same way: a non-tracking strobe is followed by a tracking strobe with zero error. A driver task models each expected increment and pushes it into a queue. The monitor compares it with `inc_o` on the cycle after each strobe.

// File: rtl/lockloop_pkg.sv
package lockloop_pkg;
  typedef enum logic {MODE_NOMINAL = 1'b0, MODE_TRACK = 1'b1} mode_e;
endpackage

// File: rtl/lockloop_pi.sv
module lockloop_pi #(
  parameter int DEV_W    = 16,
  parameter int KP_SHIFT = 2,
  parameter int KI_SHIFT = 4,
  parameter int INT_LIM  = 64,
  localparam int ERR_W   = DEV_W + 1,
  localparam int CORR_W  = ERR_W + 1
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     upd_i,
  input  logic                     track_i,
  input  logic signed [DEV_W-1:0]  freq_dev_i,
  input  logic signed [DEV_W-1:0]  phase_dev_i,
  output logic signed [CORR_W-1:0] corr_o
);
  logic signed [ERR_W-1:0] err, pterm, iterm, integ_q, integ_next;
  logic signed [ERR_W:0]   isum;

  always_comb begin
    err   = ERR_W'(freq_dev_i) + ERR_W'(phase_dev_i);
    pterm = err >>> KP_SHIFT;
    iterm = err >>> KI_SHIFT;
    isum  = CORR_W'(integ_q) + CORR_W'(iterm);
    if (isum > INT_LIM)        integ_next = ERR_W'(INT_LIM);
    else if (isum < -INT_LIM)  integ_next = ERR_W'(-INT_LIM);
    else                       integ_next = ERR_W'(isum);
    corr_o = CORR_W'(pterm) + CORR_W'(integ_next);
  end

  always_ff @(posedge clk) begin
    if (rst)                  integ_q <= '0;
    else if (upd_i && track_i) integ_q <= integ_next;
    else if (upd_i)           integ_q <= '0;
  end

  p_integ_sat_r3: assert property (@(posedge clk) disable iff (rst)
    (integ_q <= INT_LIM) && (integ_q >= -INT_LIM));
  p_integ_clear_r5: assert property (@(posedge clk) disable iff (rst)
    (upd_i && !track_i) |=> (integ_q == '0));
endmodule

// File: rtl/lockloop_clamp.sv
module lockloop_clamp #(
  parameter int          ACC_W       = 16,
  parameter int          CORR_W      = 18,
  parameter int unsigned NOM_INC     = 1024,
  parameter int          CLAMP_SHIFT = 3,
  localparam int         SUM_W       = ACC_W + CORR_W + 1
) (
  input  logic signed [CORR_W-1:0] corr_i,
  output logic        [ACC_W-1:0]  inc_o
);
  localparam int unsigned DELTA = NOM_INC >> CLAMP_SHIFT;
  localparam logic signed [SUM_W-1:0] LO = SUM_W'(NOM_INC - DELTA);
  localparam logic signed [SUM_W-1:0] HI = SUM_W'(NOM_INC + DELTA);
  localparam logic signed [SUM_W-1:0] NOM = SUM_W'(NOM_INC);

  logic signed [SUM_W-1:0] raw;

  always_comb begin
    raw = NOM + SUM_W'(corr_i);
    if (raw > HI)      inc_o = ACC_W'(HI);
    else if (raw < LO) inc_o = ACC_W'(LO);
    else               inc_o = ACC_W'(raw);
  end
endmodule

// File: rtl/lockloop_nco.sv
module lockloop_nco #(
  parameter int ACC_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [ACC_W-1:0] inc_i,
  output logic             tick_o
);
  logic [ACC_W-1:0] acc_q;
  logic [ACC_W:0]   nxt;

  assign nxt = {1'b0, acc_q} + {1'b0, inc_i};

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q  <= '0;
      tick_o <= 1'b0;
    end else begin
      acc_q  <= nxt[ACC_W-1:0];
      tick_o <= nxt[ACC_W];
    end
  end

  // increments stay below half the accumulator range, so wraps are never back to back
  p_tick_single_r7: assert property (@(posedge clk) disable iff (rst)
    tick_o |=> !tick_o);
endmodule

// File: rtl/sampclk_lock_loop.sv
module sampclk_lock_loop #(
  parameter int          ACC_W       = 16,
  parameter int          DEV_W       = 16,
  parameter int unsigned NOM_INC     = 1024,
  parameter int          CLAMP_SHIFT = 3,
  parameter int          KP_SHIFT    = 2,
  parameter int          KI_SHIFT    = 4,
  parameter int          INT_LIM     = 64
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    upd_i,
  input  logic                    track_i,
  input  logic signed [DEV_W-1:0] freq_dev_i,
  input  logic signed [DEV_W-1:0] phase_dev_i,
  output logic [ACC_W-1:0]        inc_o,
  output logic                    tick_o
);
  import lockloop_pkg::*;
  localparam int CORR_W = DEV_W + 2;
  localparam logic [ACC_W-1:0] NOM_V = ACC_W'(NOM_INC);
  localparam logic [ACC_W-1:0] LO_V  = ACC_W'(NOM_INC - (NOM_INC >> CLAMP_SHIFT));
  localparam logic [ACC_W-1:0] HI_V  = ACC_W'(NOM_INC + (NOM_INC >> CLAMP_SHIFT));

  logic signed [CORR_W-1:0] corr;
  logic [ACC_W-1:0]         clamped, inc_q;
  mode_e                    mode_now;

  assign mode_now = track_i ? MODE_TRACK : MODE_NOMINAL;

  lockloop_pi #(.DEV_W(DEV_W), .KP_SHIFT(KP_SHIFT), .KI_SHIFT(KI_SHIFT),
                .INT_LIM(INT_LIM)) u_pi (
    .clk(clk), .rst(rst), .upd_i(upd_i), .track_i(track_i),
    .freq_dev_i(freq_dev_i), .phase_dev_i(phase_dev_i), .corr_o(corr));

  lockloop_clamp #(.ACC_W(ACC_W), .CORR_W(CORR_W), .NOM_INC(NOM_INC),
                   .CLAMP_SHIFT(CLAMP_SHIFT)) u_clamp (
    .corr_i(corr), .inc_o(clamped));

  always_ff @(posedge clk) begin
    if (rst) inc_q <= NOM_V;
    else if (upd_i) begin
      case (mode_now)
        MODE_TRACK:   inc_q <= clamped;
        default:      inc_q <= NOM_V;
      endcase
    end
  end

  lockloop_nco #(.ACC_W(ACC_W)) u_nco (
    .clk(clk), .rst(rst), .inc_i(inc_q), .tick_o(tick_o));

  assign inc_o = inc_q;

  p_reset_state_r1: assert property (@(posedge clk)
    rst |=> (inc_q == NOM_V) && !tick_o);
  p_inc_range_r4: assert property (@(posedge clk) disable iff (rst)
    (inc_q >= LO_V) && (inc_q <= HI_V));
  p_nominal_load_r5: assert property (@(posedge clk) disable iff (rst)
    (upd_i && !track_i) |=> (inc_q == NOM_V));
  p_hold_r6: assert property (@(posedge clk) disable iff (rst)
    !upd_i |=> $stable(inc_q));
endmodule

// File: tb/tb_sampclk_lock_loop.sv
module tb_sampclk_lock_loop;
  localparam int CLK_PERIOD = 10;
  localparam int NOM = 1024, KP = 2, KI = 4, LIM = 64, CS = 3;
  localparam int LO = NOM - (NOM >> CS), HI = NOM + (NOM >> CS);

  logic clk = 1'b0, rst = 1'b1, upd = 1'b0, trk = 1'b0;
  logic signed [15:0] fdev = '0, pdev = '0;
  logic [15:0] inc;
  logic tick;

  typedef struct { int expv; string tag; } item_t;
  item_t sb_q[$];
  int errors = 0, checks = 0, integ_m = 0;
  bit done = 0;

  sampclk_lock_loop #(.ACC_W(16), .DEV_W(16), .NOM_INC(NOM), .CLAMP_SHIFT(CS),
    .KP_SHIFT(KP), .KI_SHIFT(KI), .INT_LIM(LIM)) dut (
    .clk(clk), .rst(rst), .upd_i(upd), .track_i(trk),
    .freq_dev_i(fdev), .phase_dev_i(pdev), .inc_o(inc), .tick_o(tick));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(string tag, int act, int expv);
    checks++;
    if (act != expv) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  // driver: one strobe, expected increment pushed to the scoreboard
  task automatic strobe(int f, int p, bit t, string tag);
    int e, raw;
    item_t it;
    @(negedge clk);
    fdev = 16'(f); pdev = 16'(p); trk = t; upd = 1'b1;
    e = f + p;
    if (t) begin
      integ_m = integ_m + (e >>> KI);
      if (integ_m > LIM) integ_m = LIM;
      if (integ_m < -LIM) integ_m = -LIM;
      raw = NOM + (e >>> KP) + integ_m;
      if (raw > HI) raw = HI;
      if (raw < LO) raw = LO;
    end else begin
      integ_m = 0;
      raw = NOM;
    end
    it.expv = raw; it.tag = tag;
    sb_q.push_back(it);
    @(negedge clk);
    upd = 1'b0;
  endtask

  // monitor
  initial begin
    forever begin
      bit seen;
      item_t it;
      @(posedge clk);
      seen = upd;
      @(negedge clk);
      if (seen && sb_q.size() > 0) begin
        it = sb_q.pop_front();
        check(it.tag, int'(inc), it.expv);
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int gap, cnt, hold_v;
    repeat (4) @(negedge clk);
    check("R1 reset inc", int'(inc), NOM);
    check("R1 reset tick", int'(tick), 0);
    rst = 1'b0;

    // R7 tick spacing at nominal
    @(negedge clk);
    while (!tick) @(negedge clk);
    gap = 0;
    @(negedge clk);
    check("R7 single-cycle tick", int'(tick), 0);
    gap = 1;
    while (!tick) begin @(negedge clk); gap++; end
    check("R7 tick interval", gap, 64);

    strobe(40, 0, 1'b1, "R2 frequency error");
    strobe(-20, 20, 1'b1, "R2 summed errors cancel");
    @(negedge clk);
    hold_v = int'(inc);
    fdev = 16'sd500; pdev = -16'sd300; trk = 1'b1;
    repeat (5) @(negedge clk);
    check("R6 hold without strobe", int'(inc), hold_v);
    trk = 1'b0;
    repeat (3) @(negedge clk);
    check("R6 track change ignored", int'(inc), hold_v);

    strobe(-7, 2, 1'b1, "R2 negative small error");
    strobe(1000, 0, 1'b1, "R4 upper clamp");
    strobe(0, 0, 1'b1, "R3 integrator saturated high");
    strobe(2000, 1000, 1'b1, "R4 upper clamp again");
    strobe(0, 0, 1'b1, "R3 saturation holds");
    strobe(-2000, -2000, 1'b1, "R4 lower clamp");
    strobe(0, 0, 1'b1, "R3 integrator saturated low");
    strobe(300, 300, 1'b0, "R5 nominal on low current");
    strobe(0, 0, 1'b1, "R5 integrator cleared");
    strobe(-100, 36, 1'b1, "R2 mixed signs");
    strobe(0, 0, 1'b0, "R5 back to nominal");
    repeat (3) @(negedge clk);

    // R7 tick count at nominal over ten periods
    cnt = 0;
    for (int i = 0; i < 640; i++) begin
      @(negedge clk);
      if (tick) cnt++;
    end
    check("R7 ticks per 640 cycles", cnt, 10);
    check("R7 scoreboard drained", sb_q.size(), 0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule